// File: doc/BRIEF.md
# SMBus Control Register Target for a Clock Fan-out

This block is the serial control port of a four-output clock fan-out device. It watches an open-drain two-wire bus, made of a clock line and a data line, and answers one fixed 7-bit device address. Behind the port sits a bank of six byte-wide registers. Four of their bits gate the four clock outputs. Four more choose between the default output swing and a programmed one. The core oversamples both lines with a system clock, so every bus event is handled synchronously in that clock domain.

A host can address a single register, writing or reading one byte. It can also run a block transfer that walks upward through consecutive registers. Bit 7 of the command code selects between these two forms. A block write carries a length byte ahead of its data. A block read first returns the content of the count register, then the data. Reserved bits keep their reset value whatever is written to them. Register indices past the end of the bank are acknowledged but hold nothing.

Top module: `smbus_clkctl_regs`

## Requirements
- R1: After reset, out_en is 4'b1111, amp_prog is 1, amp_code is 3'b101 and sda_oe is 0.
- R2: The target acknowledges an address byte whose upper seven bits are 7'h6B (D6h to write, D7h to read). Any other address gets no acknowledge, and the target ignores the bus until the next start condition.
- R3: In a command byte, bit 7 = 1 selects single-byte mode and bit 7 = 0 selects block mode. Bits 6:0 give the first register index.
- R4: A byte write (start, D6h, command, data, stop) updates one register. out_en[0] follows reg1 bit 2, out_en[1] follows reg1 bit 0, out_en[2] follows reg2 bit 7, out_en[3] follows reg2 bit 6, amp_prog follows reg5 bit 7 and amp_code follows reg5 bits 6:4.
- R5: A byte read (start, D6h, command, repeated start, D7h, data, host NACK, stop) returns the register most significant bit first. The reset values of reg0 to reg5 are 00h, 05h, C0h, 08h, 06h and D8h.
- R6: Write masks are reg0 00h, reg1 05h, reg2 C0h, reg3 FFh, reg4 FFh and reg5 F0h. Bits outside a mask ignore writes and read back their reset value.
- R7: In a block write, the byte after the command is a count N. The next N data bytes go to successive registers and each one is acknowledged. Further data bytes are neither acknowledged nor written.
- R8: A block read first sends the content of reg4. It then sends registers from the start index upward for as long as the host acknowledges, and stops after a host NACK.
- R9: Indices 6 to 127 are acknowledged. Writes to them change nothing, and reads from them return 00h.
- R10: The target changes sda_oe only while the synchronized clock line is low. It releases the data line on every start and stop condition.
- R11: Reg3 and reg4 are fully writable. After reg4 is written, block reads return the new value as their count byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge or read data 0) |
| out_en | output | 4 | Per-output clock enable, 1 = running |
| amp_prog | output | 1 | 1 = use amp_code, 0 = default swing |
| amp_code | output | 3 | Swing code, 000 = 300 mV up to 111 = 1000 mV in 100 mV steps |

## Verification
The hardest state to reach is a block write that runs past its own length field. Here the target must stop acknowledging in the middle of a transfer while still ignoring data. The stimulus sends a count of three followed by four data bytes. It then checks that the fourth byte gets no acknowledge, and reads back the register that byte would have hit. A second hard spot is a block read that walks off the end of the bank. The host acknowledges past index 5, which makes the target serve an empty index from its running pointer. In the same way, after reg4 is rewritten, the count byte of a later block read shows the new length.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;

    localparam int          NUM_REGS     = 6;
    localparam int          IDX_W        = 7;
    localparam logic [6:0]  DEV_ADDR     = 7'h6B;

    localparam int          REG_OE_A     = 1;
    localparam int          REG_OE_B     = 2;
    localparam int          REG_CNT      = 4;
    localparam int          REG_AMP      = 5;

    localparam int          OE0_BIT      = 2;
    localparam int          OE1_BIT      = 0;
    localparam int          OE2_BIT      = 7;
    localparam int          OE3_BIT      = 6;
    localparam int          AMP_SEL_BIT  = 7;
    localparam int          AMP_CODE_LSB = 4;

    function automatic logic [7:0] reg_rst(input int idx);
        case (idx)
            1:       return 8'h05;
            2:       return 8'hC0;
            3:       return 8'h08;
            4:       return 8'h06;
            5:       return 8'hD8;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            1:       return 8'h05;
            2:       return 8'hC0;
            3:       return 8'hFF;
            4:       return 8'hFF;
            5:       return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    typedef enum logic [2:0] {
        L_IDLE,
        L_RX,
        L_RXACK,
        L_TX,
        L_TXACK
    } link_st_e;

    typedef enum logic [1:0] {
        P_ADDR,
        P_CMD,
        P_COUNT,
        P_DATA
    } rx_phase_e;

    typedef struct packed {
        link_st_e         st;
        rx_phase_e        ph;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic [7:0]       txreg;
        logic [IDX_W-1:0] ptr;
        logic             blk;
        logic [7:0]       remain;
        logic             go_tx;
        logic             more;
        logic             oe;
    } link_s;

    localparam link_s LINK_RST = '{L_IDLE, P_ADDR, 4'd0, 8'd0, 8'd0, '0,
                                   1'b0, 8'd0, 1'b0, 1'b0, 1'b0};

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_s;

    sync_s sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_pipe = {sync_q.scl_pipe[STAGES-2:0], scl_i};
        sync_d.sda_pipe = {sync_q.sda_pipe[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_pipe[STAGES-1];
        sync_d.sda_prev = sync_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_s     = sync_q.scl_pipe[STAGES-1];
    assign sda_s     = sync_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign start_det = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/smb_link.sv
module smb_link
    import smb_regs_pkg::*;
#(
    parameter logic [6:0] ADDR = DEV_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       cnt_byte,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);

    link_s link_d, link_q;

    always_comb begin
        link_d  = link_q;
        wr_en   = 1'b0;
        wr_idx  = link_q.ptr;
        wr_data = link_q.shreg;

        if (start_det) begin
            link_d.st     = L_RX;
            link_d.ph     = P_ADDR;
            link_d.bitcnt = 4'd0;
            link_d.go_tx  = 1'b0;
            link_d.oe     = 1'b0;
        end else if (stop_det) begin
            link_d.st = L_IDLE;
            link_d.oe = 1'b0;
        end else begin
            case (link_q.st)
                L_RX: begin
                    if (scl_rise) begin
                        link_d.shreg  = {link_q.shreg[6:0], sda_s};
                        link_d.bitcnt = link_q.bitcnt + 4'd1;
                    end else if (scl_fall && link_q.bitcnt == 4'd8) begin
                        link_d.st    = L_RXACK;
                        link_d.go_tx = 1'b0;
                        link_d.oe    = 1'b1;
                        case (link_q.ph)
                            P_ADDR: begin
                                if (link_q.shreg[7:1] != ADDR) begin
                                    link_d.st = L_IDLE;
                                    link_d.oe = 1'b0;
                                end else if (link_q.shreg[0]) begin
                                    link_d.go_tx = 1'b1;
                                    if (link_q.blk) begin
                                        link_d.txreg = cnt_byte;
                                    end else begin
                                        link_d.txreg = rd_data;
                                        link_d.ptr   = link_q.ptr + 1'b1;
                                    end
                                end else begin
                                    link_d.ph = P_CMD;
                                end
                            end
                            P_CMD: begin
                                link_d.blk = ~link_q.shreg[7];
                                link_d.ptr = link_q.shreg[IDX_W-1:0];
                                link_d.ph  = link_q.shreg[7] ? P_DATA : P_COUNT;
                            end
                            P_COUNT: begin
                                link_d.remain = link_q.shreg;
                                link_d.ph     = P_DATA;
                            end
                            default: begin
                                if (link_q.blk && link_q.remain == 8'd0) begin
                                    link_d.oe = 1'b0;
                                end else begin
                                    wr_en      = 1'b1;
                                    link_d.ptr = link_q.ptr + 1'b1;
                                    if (link_q.blk) begin
                                        link_d.remain = link_q.remain - 8'd1;
                                    end
                                end
                            end
                        endcase
                    end
                end
                L_RXACK: begin
                    if (scl_fall) begin
                        link_d.bitcnt = 4'd0;
                        if (link_q.go_tx) begin
                            link_d.st = L_TX;
                            link_d.oe = ~link_q.txreg[7];
                        end else begin
                            link_d.st = L_RX;
                            link_d.oe = 1'b0;
                        end
                    end
                end
                L_TX: begin
                    if (scl_rise) begin
                        link_d.bitcnt = link_q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (link_q.bitcnt == 4'd8) begin
                            link_d.st = L_TXACK;
                            link_d.oe = 1'b0;
                        end else begin
                            link_d.txreg = {link_q.txreg[6:0], 1'b0};
                            link_d.oe    = ~link_q.txreg[6];
                        end
                    end
                end
                L_TXACK: begin
                    if (scl_rise) begin
                        link_d.more = ~sda_s;
                        if (!sda_s) begin
                            link_d.txreg = rd_data;
                            link_d.ptr   = link_q.ptr + 1'b1;
                        end
                    end else if (scl_fall) begin
                        link_d.bitcnt = 4'd0;
                        if (link_q.more) begin
                            link_d.st = L_TX;
                            link_d.oe = ~link_q.txreg[7];
                        end else begin
                            link_d.st = L_IDLE;
                            link_d.oe = 1'b0;
                        end
                    end
                end
                default: begin
                    link_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= LINK_RST;
        end else begin
            link_q <= link_d;
        end
    end

    assign rd_idx = link_q.ptr;
    assign sda_oe = link_q.oe;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [7:0]       cnt_byte,
    output logic [3:0]       out_en,
    output logic             amp_prog,
    output logic [2:0]       amp_code
);

    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RST_V = reg_rst(g);
        localparam logic [7:0] MASK  = reg_wmask(g);

        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && wr_idx == IDX_W'(g)) begin
                regs_d[g] = (wr_data & MASK) | (RST_V & ~MASK);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= RST_V;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    assign cnt_byte  = regs_q[REG_CNT];
    assign out_en[0] = regs_q[REG_OE_A][OE0_BIT];
    assign out_en[1] = regs_q[REG_OE_A][OE1_BIT];
    assign out_en[2] = regs_q[REG_OE_B][OE2_BIT];
    assign out_en[3] = regs_q[REG_OE_B][OE3_BIT];
    assign amp_prog  = regs_q[REG_AMP][AMP_SEL_BIT];
    assign amp_code  = regs_q[REG_AMP][AMP_CODE_LSB +: 3];

endmodule

// File: rtl/smbus_clkctl_regs.sv
module smbus_clkctl_regs
    import smb_regs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR        = DEV_ADDR
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [3:0] out_en,
    output logic       amp_prog,
    output logic [2:0] amp_code
);

    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic [7:0]       rd_data;
    logic [7:0]       cnt_byte;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    smb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_link #(
        .ADDR (ADDR)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .cnt_byte  (cnt_byte),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    smb_regbank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cnt_byte (cnt_byte),
        .out_en   (out_en),
        .amp_prog (amp_prog),
        .amp_code (amp_code)
    );

endmodule

// File: rtl/smb_regs_chk.sv
module smb_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       wr_en,
    input logic       sda_oe,
    input logic [3:0] out_en,
    input logic       amp_prog,
    input logic [2:0] amp_code
);

    // R10: the data line only moves while the clock line is low
    assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R10: a start condition leaves the data line released
    assert_start_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R10: a stop condition leaves the data line released
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4: output enables move only on a register write
    assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(out_en));

    // R4: swing controls move only on a register write
    assert_amp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(amp_prog) && $stable(amp_code)));

endmodule

bind smbus_clkctl_regs smb_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_en     (wr_en),
    .sda_oe    (sda_oe),
    .out_en    (out_en),
    .amp_prog  (amp_prog),
    .amp_code  (amp_code)
);

// File: tb/smbus_clkctl_regs_tb.sv
module smbus_clkctl_regs_tb;

    localparam int HP = 20;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_r = 1'b1;
    logic       host_low = 1'b0;
    logic       sda_oe;
    logic [3:0] out_en;
    logic       amp_prog;
    logic [2:0] amp_code;
    wire        sda_line = !(host_low || sda_oe);

    int         n_vec = 0;
    int         n_bad = 0;
    logic       done = 1'b0;
    logic [7:0] mdl [6];
    exp_item_t  exp_q [$];
    logic [7:0] obs_q [$];

    always #4 clk = ~clk;

    smbus_clkctl_regs u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_r),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .out_en   (out_en),
        .amp_prog (amp_prog),
        .amp_code (amp_code)
    );

    function automatic logic [7:0] wmask(input int i);
        case (i)
            1: return 8'h05;
            2: return 8'hC0;
            3: return 8'hFF;
            4: return 8'hFF;
            5: return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] mdl_get(input int i);
        return (i < 6) ? mdl[i] : 8'h00;
    endfunction

    task automatic mdl_put(input int i, input logic [7:0] v);
        if (i < 6) mdl[i] = (v & wmask(i)) | (mdl[i] & ~wmask(i));
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ports(input string tag);
        chk({tag, " out_en"}, {4'h0, out_en},
            {4'h0, mdl[2][6], mdl[2][7], mdl[1][0], mdl[1][2]});
        chk({tag, " amp_prog"}, {7'h0, amp_prog}, {7'h0, mdl[5][7]});
        chk({tag, " amp_code"}, {5'h0, amp_code}, {5'h0, mdl[5][6:4]});
    endtask

    // scoreboard monitor: pairs each received byte with its expected item
    initial begin
        forever begin
            @(negedge clk);
            if (obs_q.size() > 0 && exp_q.size() > 0) begin
                exp_item_t e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                chk(e.tag, o, e.val);
            end
        end
    end

    task automatic half();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        host_low = 1'b0; half();
        scl_r = 1'b1;    half();
        host_low = 1'b1; half();
        scl_r = 1'b0;    half();
    endtask

    task automatic bus_stop();
        host_low = 1'b1; half();
        scl_r = 1'b1;    half();
        host_low = 1'b0; half();
        chk("R10 released after stop", {7'h0, sda_oe}, 8'h00);
    endtask

    task automatic send_bit(input logic b);
        host_low = !b; half();
        scl_r = 1'b1;  half();
        scl_r = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic recv_bit(output logic b);
        host_low = 1'b0; half();
        scl_r = 1'b1;
        repeat (HP / 2) @(negedge clk);
        b = sda_line;
        repeat (HP / 2) @(negedge clk);
        scl_r = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string tag);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        chk({tag, " ack"}, {7'h0, !b}, {7'h0, exp_ack});
    endtask

    task automatic recv_byte(input logic host_ack);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!host_ack);
        obs_q.push_back(v);
    endtask

    task automatic byte_write(input int idx, input logic [7:0] v, input string tag);
        bus_start();
        send_byte(8'hD6, 1'b1, {tag, " addr"});
        send_byte(8'h80 | 8'(idx), 1'b1, {tag, " cmd"});
        send_byte(v, 1'b1, {tag, " data"});
        bus_stop();
        mdl_put(idx, v);
    endtask

    task automatic byte_read(input int idx, input string tag);
        bus_start();
        send_byte(8'hD6, 1'b1, {tag, " addr"});
        send_byte(8'h80 | 8'(idx), 1'b1, {tag, " cmd"});
        bus_start();
        send_byte(8'hD7, 1'b1, {tag, " raddr"});
        exp_q.push_back('{mdl_get(idx), tag});
        recv_byte(1'b0);
        bus_stop();
    endtask

    task automatic blk_read(input int idx, input int n, input string tag);
        bus_start();
        send_byte(8'hD6, 1'b1, {tag, " addr"});
        send_byte(8'(idx), 1'b1, {tag, " cmd"});
        bus_start();
        send_byte(8'hD7, 1'b1, {tag, " raddr"});
        exp_q.push_back('{mdl[4], {tag, " count"}});
        recv_byte(1'b1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back('{mdl_get(idx + k), {tag, " data"}});
            recv_byte(k < n - 1);
        end
        bus_stop();
    endtask

    initial begin
        mdl[0] = 8'h00; mdl[1] = 8'h05; mdl[2] = 8'hC0;
        mdl[3] = 8'h08; mdl[4] = 8'h06; mdl[5] = 8'hD8;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state at the ports
        chk_ports("R1 reset");
        chk("R1 sda_oe reset", {7'h0, sda_oe}, 8'h00);

        // R5 / R3: single-byte reads of every reset value
        for (int i = 0; i < 6; i++) byte_read(i, "R5 reset readback");

        // R6: reserved bits of reg1 hold; R4: output mapping
        byte_write(1, 8'hFF, "R6 reg1 all ones");
        byte_read(1, "R6 reg1 masked");
        byte_write(1, 8'h04, "R4 reg1 oe1 off");
        chk_ports("R4 after reg1");
        byte_write(2, 8'h7F, "R4 reg2 oe2 off");
        chk_ports("R4 after reg2");
        byte_read(2, "R6 reg2 masked");
        byte_write(5, 8'h2F, "R4 reg5 swing");
        chk_ports("R4 after reg5");
        byte_read(5, "R6 reg5 masked");
        byte_write(0, 8'hFF, "R6 reg0 reserved");
        byte_read(0, "R6 reg0 readback");

        // R2: foreign address ignored until next start
        bus_start();
        send_byte(8'hD4, 1'b0, "R2 wrong addr");
        send_byte(8'h81, 1'b0, "R2 ignored byte");
        send_byte(8'h00, 1'b0, "R2 ignored byte");
        bus_stop();
        chk_ports("R2 no change");
        byte_read(1, "R2 reg1 unchanged");

        // R9: indices past the bank
        byte_write(9, 8'h5A, "R9 write high index");
        byte_read(9, "R9 read high index");
        chk_ports("R9 no change");

        // R7: block write with one byte beyond its count
        bus_start();
        send_byte(8'hD6, 1'b1, "R7 addr");
        send_byte(8'h01, 1'b1, "R7 cmd");
        send_byte(8'h03, 1'b1, "R7 count");
        send_byte(8'h05, 1'b1, "R7 data0");
        send_byte(8'hC0, 1'b1, "R7 data1");
        send_byte(8'h3C, 1'b1, "R7 data2");
        send_byte(8'hFF, 1'b0, "R7 excess");
        bus_stop();
        mdl_put(1, 8'h05); mdl_put(2, 8'hC0); mdl_put(3, 8'h3C);
        chk_ports("R7 after block write");
        byte_read(4, "R7 reg4 untouched");

        // R8: block read over the whole bank
        blk_read(0, 6, "R8 full block read");

        // R11: rewrite reg3/reg4, count byte follows
        byte_write(4, 8'h02, "R11 reg4");
        byte_write(3, 8'hA5, "R11 reg3");
        blk_read(2, 2, "R11 block read count");

        // R9 / R8: block read walking past the last register
        blk_read(4, 3, "R9 block read past end");

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule